// File: doc/BRIEF.md
# Gated Pixel Output Port

This block moves a stream of 16-bit pixel words from an internal buffer onto a data bus that it shares with a memory port. Alongside the data it drives a gated pixel clock, an active-low horizontal sync, an active-high vertical sync and a data-valid qualifier. The pixel words arrive on a ready/valid stream. Each word may carry a start-of-line marker, a start-of-frame marker, or both.

The block runs on `clk`, which runs at twice the rate of the internal video source clock, so one `clk` cycle is one half period of that source clock. With the divide-by-1 ratio the pixel clock period is 2 `clk` cycles. With the divide-by-2 ratio it is 4 `clk` cycles. Every accepted word fills exactly one pixel clock period. In 16-bit mode the whole word is on the bus for that period. In 8-bit mode the low byte is sent on the first half of the period and the high byte on the second half, both on bus lanes 7:0, so a byte is centred on each clock edge. The mode inputs are sampled only while the port is idle.

`bus_busy` tells an external arbiter when the shared bus belongs to the video path. Whenever data-valid is low, the data pins carry zero and the bus may be handed to the memory port.

Top module: `vidout_port`

## Requirements
- R1: While reset is asserted and after it is released with no input, pixel clock, vertical sync, data-valid, bus_busy and the data bus are all 0, and horizontal sync is 1.
- R2: In 16-bit mode with the divide-by-1 ratio (mode8=0, div2=0), a back-to-back stream gives one word every 2 cycles. The pixel clock is low in cycle 0 and high in cycle 1 of each period. Data-valid is high and the bus holds the whole word for both cycles.
- R3: With div2=1 in 16-bit mode, each period is 4 cycles. The pixel clock is high only in cycles 1 and 2 of the period, and the word is held for all 4 cycles.
- R4: With mode8=1 the divide-by-2 timing is used whatever div2 says. Bus bits 7:0 carry word bits 7:0 in period cycles 0 and 1 and word bits 15:8 in cycles 2 and 3. Bus bits 15:8 are 0.
- R5: With inv=1 the pixel clock pattern of R2 to R4 is inverted.
- R6: The pixel clock is gated. Whenever bus_busy is low it stays at its inactive level, which is the value of inv, and it does not toggle.
- R7: A word with start-of-line set is preceded by exactly one pixel clock period with horizontal sync low, data-valid low and the pixel clock running. Horizontal sync is high at all other times.
- R8: Vertical sync takes the start-of-frame flag of each start-of-line word when that word's sync period begins, and holds that value until the next start-of-line word.
- R9: Each accepted word is presented for exactly one period. If the stream stalls, data-valid falls and the pixel clock stops, so no word is repeated or lost.
- R10: bus_busy is high during sync and data periods and low once the stream has drained.
- R11: Changes to mode8, div2 or inv while bus_busy is high do not affect the transfer in progress.
- R12: The data bus is 0 whenever data-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock at twice the video source clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode8 | input | 1 | 1 selects 8-bit bus mode |
| cfg_div2 | input | 1 | 1 selects the divide-by-2 pixel clock |
| cfg_inv | input | 1 | 1 inverts the pixel clock |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted this cycle |
| in_data | input | 16 | Stream pixel word |
| in_sol | input | 1 | Word starts a line |
| in_sof | input | 1 | Word starts a frame |
| vo_pclk | output | 1 | Gated pixel clock |
| vo_hsync_n | output | 1 | Horizontal sync, active low |
| vo_vsync | output | 1 | Vertical sync, active high |
| vo_dvalid | output | 1 | Data bus qualifier |
| vo_data | output | 16 | Pixel data onto the shared bus |
| bus_busy | output | 1 | Video path owns the shared bus |

## Verification
The port is driven with back-to-back word streams under each combination of width, ratio and polarity. The recorded pixel clock and data pattern inside each period separates a 2-cycle period from a 4-cycle one, and a byte-split period from a whole-word one. A line holding a start-of-frame word and then a plain start-of-line word shows whether the sync period is inserted, how long it lasts, and when vertical sync moves. A stream with a gap, and a stream whose mode inputs change during the transfer, show whether the clock is gated, whether any word is repeated or dropped, and whether the mode inputs stay frozen while the port is busy.

// File: rtl/vidout_pkg.sv
package vidout_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DATA} vo_state_e;

  typedef struct packed {
    logic mode8;
    logic div2;
    logic inv;
  } vo_cfg_t;
endpackage

// File: rtl/vidout_timer.sv
module vidout_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow,
  output logic [CNT_W-1:0] cnt_q,
  output logic             period_end,
  output logic             phase_hi,
  output logic             late_half
);
  localparam logic [CNT_W-1:0] HALF_FAST = CNT_W'(1);
  localparam logic [CNT_W-1:0] HALF_SLOW = CNT_W'(2);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(3);

  logic [CNT_W-1:0] half, last, cnt_nx;

  always_comb begin
    half       = slow ? HALF_SLOW : HALF_FAST;
    last       = slow ? LAST_SLOW : LAST_FAST;
    period_end = run && (cnt_q == last);
    phase_hi   = run && (cnt_q != '0) && (cnt_q <= half);
    late_half  = (cnt_q >= half);
    if (!run || period_end) cnt_nx = '0;
    else                    cnt_nx = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  // R3: the period counter never passes the last cycle of the selected ratio
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
  // R9: a stopped port leaves the counter parked at zero
  a_r9_parked_counter: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> cnt_q == '0);
endmodule

// File: rtl/vidout_seq.sv
module vidout_seq
  import vidout_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic      in_sol,
  input  logic      in_sof,
  input  logic      period_end,
  output logic      in_ready,
  output vo_state_e state_q,
  output logic      vsync_q
);
  vo_state_e state_nx;
  logic      vsync_nx;

  always_comb begin
    state_nx = state_q;
    vsync_nx = vsync_q;
    in_ready = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          if (in_sol) begin
            state_nx = ST_SYNC;
            vsync_nx = in_sof;
          end else begin
            in_ready = 1'b1;
            state_nx = ST_DATA;
          end
        end
      end
      ST_SYNC: begin
        if (period_end) begin
          if (in_valid) begin
            in_ready = 1'b1;
            state_nx = ST_DATA;
          end else begin
            state_nx = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (period_end) begin
          if (in_valid && in_sol) begin
            state_nx = ST_SYNC;
            vsync_nx = in_sof;
          end else if (in_valid) begin
            in_ready = 1'b1;
          end else begin
            state_nx = ST_IDLE;
          end
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vsync_q <= 1'b0;
    end else begin
      state_q <= state_nx;
      vsync_q <= vsync_nx;
    end
  end

  // R8: vertical sync only moves as a sync period opens
  a_r8_vsync_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync_q) |-> state_q == ST_SYNC);
endmodule

// File: rtl/vidout_lanes.sv
module vidout_lanes #(
  parameter int WORD_W = 16
) (
  input  logic              active,
  input  logic              mode8,
  input  logic              late_half,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] bus
);
  localparam int LANE_W = WORD_W / 2;

  logic [LANE_W-1:0] narrow;

  always_comb begin
    narrow = late_half ? word[WORD_W-1:LANE_W] : word[LANE_W-1:0];
    if (!active)    bus = '0;
    else if (mode8) bus = {{(WORD_W-LANE_W){1'b0}}, narrow};
    else            bus = word;
  end
endmodule

// File: rtl/vidout_port.sv
module vidout_port
  import vidout_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode8,
  input  logic              cfg_div2,
  input  logic              cfg_inv,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_sol,
  input  logic              in_sof,
  output logic              vo_pclk,
  output logic              vo_hsync_n,
  output logic              vo_vsync,
  output logic              vo_dvalid,
  output logic [WORD_W-1:0] vo_data,
  output logic              bus_busy
);
  localparam int CNT_W = 2;

  vo_state_e         state_q;
  vo_cfg_t           cfg_q, cfg_nx;
  logic [WORD_W-1:0] word_q, word_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic              period_end, phase_hi, late_half, load, slow;

  assign load = in_valid && in_ready;
  assign slow = cfg_q.div2 || cfg_q.mode8;

  always_comb begin
    cfg_nx  = cfg_q;
    word_nx = word_q;
    if (state_q == ST_IDLE) cfg_nx = '{mode8: cfg_mode8, div2: cfg_div2, inv: cfg_inv};
    if (load)               word_nx = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      word_q <= '0;
    end else begin
      cfg_q  <= cfg_nx;
      word_q <= word_nx;
    end
  end

  vidout_seq u_seq (
    .clk, .rst_n, .in_valid, .in_sol, .in_sof,
    .period_end, .in_ready, .state_q, .vsync_q(vo_vsync)
  );

  vidout_timer #(.CNT_W(CNT_W)) u_timer (
    .clk, .rst_n, .run(bus_busy), .slow,
    .cnt_q, .period_end, .phase_hi, .late_half
  );

  vidout_lanes #(.WORD_W(WORD_W)) u_lanes (
    .active(vo_dvalid), .mode8(cfg_q.mode8), .late_half,
    .word(word_q), .bus(vo_data)
  );

  assign bus_busy   = (state_q != ST_IDLE);
  assign vo_dvalid  = (state_q == ST_DATA);
  assign vo_hsync_n = (state_q != ST_SYNC);
  assign vo_pclk    = cfg_q.inv ^ phase_hi;

  // R10: qualified data only while the bus is claimed
  a_r10_dv_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    vo_dvalid |-> bus_busy);
  // R7: the sync period carries no data
  a_r7_sync_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !vo_hsync_n |-> (!vo_dvalid && bus_busy));
  // R11: mode settings frozen across a transfer
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && $past(bus_busy)) |-> $stable(cfg_q));
  // R6: parked clock does not toggle while idle
  a_r6_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && !$past(bus_busy) && $stable(cfg_q.inv)) |-> $stable(vo_pclk));
  // R12: bus released to zero outside data-valid
  a_r12_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !vo_dvalid |-> vo_data == '0);
endmodule

// File: tb/vidout_port_test.sv
module vidout_port_test;
  localparam int CLK_P = 10;
  localparam int WW = 16;
  localparam int RMAX = 256;

  logic clk, rst_n, cfg_mode8, cfg_div2, cfg_inv, in_valid, in_ready, in_sol, in_sof;
  logic [WW-1:0] in_data, vo_data;
  logic vo_pclk, vo_hsync_n, vo_vsync, vo_dvalid, bus_busy;

  int checks = 0, fails = 0;
  logic [WW-1:0] wq [0:7];

  bit rec_on = 0;
  int rec_n = 0;
  logic r_pc [0:RMAX-1], r_hs [0:RMAX-1], r_vs [0:RMAX-1], r_dv [0:RMAX-1], r_bb [0:RMAX-1];
  logic [WW-1:0] r_d [0:RMAX-1];

  vidout_port #(.WORD_W(WW)) uut (
    .clk, .rst_n, .cfg_mode8, .cfg_div2, .cfg_inv, .in_valid, .in_ready,
    .in_data, .in_sol, .in_sof, .vo_pclk, .vo_hsync_n, .vo_vsync,
    .vo_dvalid, .vo_data, .bus_busy
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (rec_on && rec_n < RMAX) begin
      r_pc[rec_n] = vo_pclk; r_hs[rec_n] = vo_hsync_n; r_vs[rec_n] = vo_vsync;
      r_dv[rec_n] = vo_dvalid; r_bb[rec_n] = bus_busy; r_d[rec_n] = vo_data;
      rec_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [WW-1:0] w, input bit sol, input bit sof);
    in_valid = 1; in_data = w; in_sol = sol; in_sof = sof;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk); @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic drop_and_drain();
    in_valid = 0; in_sol = 0; in_sof = 0;
    repeat (12) @(negedge clk);
    rec_on = 0;
  endtask

  task automatic start(input bit m8, input bit d2, input bit iv);
    cfg_mode8 = m8; cfg_div2 = d2; cfg_inv = iv;
    repeat (3) @(negedge clk);
    rec_n = 0; rec_on = 1;
    @(negedge clk);
  endtask

  function automatic int first_dv();
    for (int i = 0; i < rec_n; i++) if (r_dv[i]) return i;
    return -1;
  endfunction

  // Checks a stream of nw words from wq without sync periods, period P cycles
  task automatic check_run(input int P, input bit m8, input bit iv, input int nw, input string tag);
    int f, e_pc, e_d, e_bb, ndv, h, c, k;
    logic [WW-1:0] w, ed;
    bit epc;
    f = first_dv(); e_pc = 0; e_d = 0; e_bb = 0; ndv = 0; h = P / 2;
    chk(f >= 0, {tag, " data-valid seen"}, f, 0);
    if (f < 0) return;
    for (int i = 0; i < nw * P; i++) begin
      k = f + i; c = i % P; w = wq[i / P];
      epc = iv ^ (c >= 1 && c <= h);
      ed = m8 ? {8'h00, (c >= h) ? w[15:8] : w[7:0]} : w;
      if (r_pc[k] !== epc) e_pc++;
      if (r_d[k] !== ed || r_dv[k] !== 1'b1) e_d++;
      if (r_bb[k] !== 1'b1 || r_hs[k] !== 1'b1) e_bb++;
    end
    for (int i = 0; i < rec_n; i++) if (r_dv[i]) ndv++;
    chk(e_pc == 0, {tag, " pixel clock pattern"}, e_pc, 0);
    chk(e_d == 0, {tag, " data per period"}, e_d, 0);
    chk(e_bb == 0, {tag, " R10 busy during words"}, e_bb, 0);
    chk(ndv == nw * P, {tag, " R9 valid cycle count"}, ndv, nw * P);
    k = f + nw * P;
    chk(r_dv[k] === 1'b0 && r_bb[k] === 1'b0 && r_pc[k] === iv && r_d[k] === '0,
        {tag, " R6 R10 R12 drained state"}, {r_dv[k], r_bb[k], r_pc[k]}, {2'b00, iv});
  endtask

  task automatic t_reset();
    chk(vo_pclk === 0 && vo_vsync === 0 && vo_dvalid === 0 && bus_busy === 0,
        "R1 outputs in reset", {vo_pclk, vo_vsync, vo_dvalid, bus_busy}, 0);
    chk(vo_hsync_n === 1 && vo_data === '0, "R1 hsync and bus in reset", {vo_hsync_n, vo_data}, 17'h10000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(vo_pclk === 0 && vo_hsync_n === 1 && vo_dvalid === 0 && bus_busy === 0 && vo_data === '0,
        "R1 idle after release", {vo_pclk, vo_hsync_n, vo_dvalid, bus_busy}, 4'b0100);
  endtask

  task automatic t_wide_fast();
    wq[0] = 16'hA1B2; wq[1] = 16'hC3D4; wq[2] = 16'h5E6F;
    start(0, 0, 0);
    for (int i = 0; i < 3; i++) push(wq[i], 0, 0);
    drop_and_drain();
    check_run(2, 0, 0, 3, "R2");
  endtask

  task automatic t_wide_slow();
    wq[0] = 16'h1234; wq[1] = 16'hFEDC;
    start(0, 1, 0);
    for (int i = 0; i < 2; i++) push(wq[i], 0, 0);
    drop_and_drain();
    check_run(4, 0, 0, 2, "R3");
  endtask

  task automatic t_narrow();
    wq[0] = 16'h8765; wq[1] = 16'h0FF0;
    start(1, 0, 0);
    for (int i = 0; i < 2; i++) push(wq[i], 0, 0);
    drop_and_drain();
    check_run(4, 1, 0, 2, "R4 R12");
  endtask

  task automatic t_invert();
    wq[0] = 16'h4242; wq[1] = 16'h9999;
    start(0, 0, 1);
    chk(vo_pclk === 1'b1, "R5 R6 parked level inverted", vo_pclk, 1);
    for (int i = 0; i < 2; i++) push(wq[i], 0, 0);
    drop_and_drain();
    check_run(2, 0, 1, 2, "R5");
    cfg_inv = 0;
  endtask

  task automatic t_line();
    int b, e;
    logic [WW-1:0] exp_d [0:11];
    bit exp_dv [0:11], exp_hs [0:11], exp_vs [0:11];
    start(0, 0, 0);
    push(16'h0A0A, 1, 1);
    push(16'h0B0B, 0, 0);
    push(16'h0C0C, 1, 0);
    push(16'h0D0D, 0, 0);
    drop_and_drain();
    for (int i = 0; i < 12; i++) begin
      exp_hs[i] = !(i < 2 || i == 6 || i == 7);
      exp_dv[i] = exp_hs[i];
      exp_vs[i] = (i < 6);
    end
    exp_d = '{16'h0, 16'h0, 16'h0A0A, 16'h0A0A, 16'h0B0B, 16'h0B0B,
              16'h0, 16'h0, 16'h0C0C, 16'h0C0C, 16'h0D0D, 16'h0D0D};
    b = -1;
    for (int i = 0; i < rec_n; i++) if (r_bb[i] && b < 0) b = i;
    chk(b >= 0, "R7 line started", b, 0);
    if (b < 0) return;
    e = 0;
    for (int i = 0; i < 12; i++) if (r_hs[b+i] !== exp_hs[i] || r_dv[b+i] !== exp_dv[i]) e++;
    chk(e == 0, "R7 sync period placement", e, 0);
    e = 0;
    for (int i = 0; i < 12; i++) if (r_pc[b+i] !== logic'(i % 2)) e++;
    chk(e == 0, "R7 clock runs through sync", e, 0);
    e = 0;
    for (int i = 0; i < 12; i++) if (r_vs[b+i] !== exp_vs[i]) e++;
    chk(e == 0, "R8 vertical sync span", e, 0);
    e = 0;
    for (int i = 0; i < 12; i++) if (r_d[b+i] !== exp_d[i]) e++;
    chk(e == 0, "R7 R12 data around sync", e, 0);
    chk(r_bb[b+12] === 1'b0 && r_hs[b+12] === 1'b1, "R10 line drained", {r_bb[b+12], r_hs[b+12]}, 1);
  endtask

  task automatic t_stall();
    int f, l, ndv, bad;
    start(0, 0, 0);
    push(16'h1111, 0, 0);
    in_valid = 0;
    repeat (5) @(negedge clk);
    push(16'h2222, 0, 0);
    drop_and_drain();
    f = first_dv(); l = -1; ndv = 0; bad = 0;
    for (int i = 0; i < rec_n; i++) if (r_dv[i]) begin ndv++; l = i; end
    chk(ndv == 4, "R9 no repeat or loss across stall", ndv, 4);
    for (int i = f + 2; i < l - 1; i++)
      if (r_dv[i] !== 0 || r_pc[i] !== 0 || r_bb[i] !== 0 || r_d[i] !== '0) bad++;
    chk(bad == 0 && (l - f) > 4, "R6 R10 R12 quiet gap", bad, 0);
    chk(r_d[f] === 16'h1111 && r_d[l] === 16'h2222, "R9 words in order", r_d[l], 16'h2222);
  endtask

  task automatic t_cfg_hold();
    wq[0] = 16'h3C3C; wq[1] = 16'h7E7E; wq[2] = 16'hDEAD;
    start(0, 0, 0);
    push(wq[0], 0, 0);
    cfg_mode8 = 1; cfg_div2 = 1; cfg_inv = 1;
    push(wq[1], 0, 0);
    push(wq[2], 0, 0);
    in_valid = 0; in_sol = 0; in_sof = 0;
    repeat (12) @(negedge clk);
    rec_on = 0;
    check_run(2, 0, 0, 3, "R11");
    cfg_mode8 = 0; cfg_div2 = 0; cfg_inv = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_data = '0; in_sol = 0; in_sof = 0;
    cfg_mode8 = 0; cfg_div2 = 0; cfg_inv = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_wide_fast();
    t_wide_slow();
    t_narrow();
    t_invert();
    t_line();
    t_stall();
    t_cfg_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule